// File: doc/BRIEF.md
# Three-Stage Split-Carry Multiply-Accumulate

This block is a streaming unsigned multiply-accumulate. Each clock cycle it can take one operand triple (a, b, c) and, some cycles later, it returns the value a*b + c at full 2*WIDTH precision. The arithmetic is spread over three register stages so that no single cycle holds a long logic path. The first stage forms the product. The second stage adds c to the lower half of the product and keeps the carry. The third stage adds that carry into the upper half of the product.

A one-bit valid flag travels with every operation through all three stages. A stall input freezes the whole pipeline in place. A flush input discards every operation currently in flight. Any value that meets another at a stage has been delayed by the same number of registers as its partners, so the sum always combines parts of a single operation. This applies to the addend, the upper product half, the carry and the finished lower half.

Top module: `smac_top`

## Requirements
- R1: For every accepted triple (in_valid high on an unstalled, unflushed cycle), result equals a*b + c, with c zero-extended to 2*WIDTH bits. out_valid is high on the cycle this result appears.
- R2: Latency is exactly three unstalled clock edges from acceptance to output. Triples offered on consecutive unstalled cycles give results on consecutive cycles, one per cycle.
- R3: After reset is released, out_valid stays low until three unstalled edges have passed. It rises only when the operation accepted on the first of those edges arrives.
- R4: Each result uses the c offered with its own a and b, even when c changes on every cycle.
- R5: A carry out of the lower half sum (product low half + c >= 2^WIDTH) increments the upper half. Example for WIDTH=8: a=255, b=1, c=1 gives 256. a=255, b=255, c=255 gives 65280.
- R6: While stall is high, no pipeline register changes, so result and out_valid hold their values. When stall drops, the operations in flight continue with none dropped and none repeated.
- R7: A flush on an unstalled cycle clears all three valid stages. This includes the triple offered on that same cycle. out_valid is then low for the next three output cycles unless new triples are accepted.
- R8: When stall and flush are high together, stall takes priority and the flush has no effect. Operations in flight still emerge after the stall.
- R9: A synchronous active-high reset clears every valid stage, so out_valid is low on the edge after reset and while reset is held.
- R10: A cycle with in_valid low (a bubble) produces an output cycle with out_valid low, three unstalled edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; empties the pipe |
| in_valid | input | 1 | The triple offered this cycle is a real operation |
| a | input | WIDTH | Multiplicand |
| b | input | WIDTH | Multiplier |
| c | input | WIDTH | Addend, zero-extended |
| stall | input | 1 | Freeze every pipeline register this cycle |
| flush | input | 1 | Clear all in-flight valid flags (when not stalled) |
| result | output | 2*WIDTH | a*b + c of the operation in the last stage |
| out_valid | output | 1 | result holds a real operation |

## Verification
A result is due on the third unstalled rising edge after its triple was accepted. Stalled edges do not count toward that delay, and a flush or reset on the way cancels the result. The reference shifts its three entries only on edges where stall was low. On a flush or reset it clears their valid flags. The outputs are compared against the third entry 1 ns after every edge. This covers fill after reset, back-to-back streams with varying c, carry-producing operands, stalls that hold the outputs, flushes, and stall and flush raised together.

// File: rtl/smac_pkg.sv
package smac_pkg;
   // number of register stages in the datapath: multiply, low add, carry finish
   localparam int unsigned SMAC_DEPTH = 3;
endpackage

// File: rtl/smac_dreg.sv
// Enabled data register; a parameter chooses whether reset clears it.
module smac_dreg #(
   parameter int unsigned W   = 8,
   parameter bit          RST = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (RST) begin : g_rst
         always_ff @(posedge clk) begin
            if (rst)     q <= '0;
            else if (en) q <= d;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (en) q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/smac_mul_stage.sv
// Stage one: product register plus the addend delayed by the same one stage.
module smac_mul_stage #(
   parameter int unsigned WIDTH    = 8,
   parameter bit          DATA_RST = 1'b1,
   localparam int unsigned PW      = 2 * WIDTH
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [WIDTH-1:0] c,
   output logic [PW-1:0]    prod_q,
   output logic [WIDTH-1:0] c_q
);
   logic [PW-1:0] prod_d;
   assign prod_d = PW'(a) * PW'(b);

   smac_dreg #(.W(PW), .RST(DATA_RST)) u_prod (
      .clk(clk), .rst(rst), .en(en), .d(prod_d), .q(prod_q));
   smac_dreg #(.W(WIDTH), .RST(DATA_RST)) u_addend (
      .clk(clk), .rst(rst), .en(en), .d(c), .q(c_q));
endmodule

// File: rtl/smac_lowadd_stage.sv
// Stage two: low product half plus addend, with carry and high half kept in step.
module smac_lowadd_stage #(
   parameter int unsigned WIDTH    = 8,
   parameter bit          DATA_RST = 1'b1,
   localparam int unsigned PW      = 2 * WIDTH
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [PW-1:0]    prod_q,
   input  logic [WIDTH-1:0] c_q,
   output logic [WIDTH-1:0] lo_q,
   output logic             cy_q,
   output logic [WIDTH-1:0] hi_q
);
   logic [WIDTH:0] lsum;
   assign lsum = {1'b0, prod_q[WIDTH-1:0]} + {1'b0, c_q};

   smac_dreg #(.W(WIDTH + 1), .RST(DATA_RST)) u_lsum (
      .clk(clk), .rst(rst), .en(en), .d(lsum), .q({cy_q, lo_q}));
   smac_dreg #(.W(WIDTH), .RST(DATA_RST)) u_hi (
      .clk(clk), .rst(rst), .en(en), .d(prod_q[PW-1:WIDTH]), .q(hi_q));
endmodule

// File: rtl/smac_carry_stage.sv
// Stage three: carry into the high half; low sum delayed one more stage to meet it.
module smac_carry_stage #(
   parameter int unsigned WIDTH    = 8,
   parameter bit          DATA_RST = 1'b1,
   localparam int unsigned PW      = 2 * WIDTH
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] lo_q,
   input  logic             cy_q,
   input  logic [WIDTH-1:0] hi_q,
   output logic [PW-1:0]    res_q
);
   logic [WIDTH-1:0] hi_sum;
   assign hi_sum = hi_q + {{(WIDTH - 1){1'b0}}, cy_q};

   smac_dreg #(.W(WIDTH), .RST(DATA_RST)) u_res_hi (
      .clk(clk), .rst(rst), .en(en), .d(hi_sum), .q(res_q[PW-1:WIDTH]));
   smac_dreg #(.W(WIDTH), .RST(DATA_RST)) u_res_lo (
      .clk(clk), .rst(rst), .en(en), .d(lo_q), .q(res_q[WIDTH-1:0]));
endmodule

// File: rtl/smac_valid_chain.sv
// One valid flag per stage; frozen by the enable, cleared by reset or flush.
module smac_valid_chain #(
   parameter int unsigned DEPTH = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic flush,
   input  logic in_valid,
   output logic tail
);
   logic [DEPTH-1:0] v;

   always_ff @(posedge clk) begin
      if (rst)          v <= '0;
      else if (en) begin
         if (flush)     v <= '0;
         else           v <= {v[DEPTH-2:0], in_valid};
      end
   end

   assign tail = v[DEPTH-1];
endmodule

// File: rtl/smac_top.sv
module smac_top #(
   parameter int unsigned WIDTH    = 8,
   parameter bit          DATA_RST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [WIDTH-1:0]     a,
   input  logic [WIDTH-1:0]     b,
   input  logic [WIDTH-1:0]     c,
   input  logic                 stall,
   input  logic                 flush,
   output logic [2*WIDTH-1:0]   result,
   output logic                 out_valid
);
   import smac_pkg::*;
   localparam int unsigned PW = 2 * WIDTH;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("smac_top: WIDTH must be at least 2");
      end
      if (SMAC_DEPTH != 3) begin : g_bad_depth
         $error("smac_top: datapath is built for exactly three stages");
      end
   endgenerate

   logic             en;
   logic [PW-1:0]    prod_q;
   logic [WIDTH-1:0] c_q, lo_q, hi_q;
   logic             cy_q;

   assign en = ~stall;

   smac_mul_stage #(.WIDTH(WIDTH), .DATA_RST(DATA_RST)) u_mul (
      .clk(clk), .rst(rst), .en(en), .a(a), .b(b), .c(c),
      .prod_q(prod_q), .c_q(c_q));

   smac_lowadd_stage #(.WIDTH(WIDTH), .DATA_RST(DATA_RST)) u_low (
      .clk(clk), .rst(rst), .en(en), .prod_q(prod_q), .c_q(c_q),
      .lo_q(lo_q), .cy_q(cy_q), .hi_q(hi_q));

   smac_carry_stage #(.WIDTH(WIDTH), .DATA_RST(DATA_RST)) u_fin (
      .clk(clk), .rst(rst), .en(en), .lo_q(lo_q), .cy_q(cy_q), .hi_q(hi_q),
      .res_q(result));

   smac_valid_chain #(.DEPTH(SMAC_DEPTH)) u_vld (
      .clk(clk), .rst(rst), .en(en), .flush(flush), .in_valid(in_valid),
      .tail(out_valid));
endmodule

// File: rtl/smac_chk.sv
module smac_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic               clk,
   input logic               rst,
   input logic               in_valid,
   input logic [WIDTH-1:0]   a,
   input logic [WIDTH-1:0]   b,
   input logic [WIDTH-1:0]   c,
   input logic               stall,
   input logic               flush,
   input logic [2*WIDTH-1:0] result,
   input logic               out_valid
);
   localparam int unsigned PW = 2 * WIDTH;

   logic [2:0]    mv;
   logic [PW-1:0] md0, md1, md2;
   logic [1:0]    fill;

   always_ff @(posedge clk) begin
      if (rst) begin
         mv   <= '0;
         fill <= '0;
         md0  <= '0;
         md1  <= '0;
         md2  <= '0;
      end else if (!stall) begin
         mv   <= flush ? 3'b000 : {mv[1:0], in_valid};
         md0  <= PW'(a) * PW'(b) + PW'(c);
         md1  <= md0;
         md2  <= md1;
         if (fill != 2'd3) fill <= fill + 2'd1;
      end
   end

   AST_RESULT_MATCH: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (result == md2)); // R1

   AST_VALID_TRACK: assert property (@(posedge clk) disable iff (rst)
      out_valid == mv[2]); // R2

   AST_NO_EARLY_FILL: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (fill == 2'd3)); // R3

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
      stall |=> ($stable(result) && $stable(out_valid))); // R6

   AST_FLUSH_DRAIN: assert property (@(posedge clk) disable iff (rst)
      (flush && !stall) |=> !out_valid); // R7
endmodule

bind smac_top smac_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b), .c(c),
   .stall(stall), .flush(flush), .result(result), .out_valid(out_valid));

// File: tb/tb_smac_top.sv
module tb_smac_top;
   localparam int unsigned W  = 8;
   localparam int unsigned PW = 2 * W;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [W-1:0]  a = '0, b = '0, c = '0;
   logic          stall = 1'b0, flush = 1'b0;
   logic [PW-1:0] result;
   logic          out_valid;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   // behavioural reference: three in-flight slots, slot 2 is the output
   bit      ref_v [3];
   longint  ref_d [3];

   smac_top #(.WIDTH(W)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b), .c(c),
      .stall(stall), .flush(flush), .result(result), .out_valid(out_valid));

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         errors++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic compare(input string tag);
      checks++;
      if (out_valid !== ref_v[2]) begin
         errors++;
         $display("FAIL %s out_valid actual=%b expected=%b", tag, out_valid, ref_v[2]);
      end
      if (ref_v[2]) begin
         checks++;
         if (result !== PW'(ref_d[2])) begin
            errors++;
            $display("FAIL %s result actual=%0d expected=%0d", tag, result, ref_d[2]);
         end
      end
   endtask

   task automatic step(input bit iv, input bit st, input bit fl,
                       input int xa, input int xb, input int xc, input string tag);
      @(negedge clk);
      in_valid = iv; stall = st; flush = fl;
      a = W'(xa); b = W'(xb); c = W'(xc);
      @(posedge clk);
      #1;
      if (!st) begin
         ref_v[2] = fl ? 1'b0 : ref_v[1];
         ref_v[1] = fl ? 1'b0 : ref_v[0];
         ref_v[0] = fl ? 1'b0 : iv;
         ref_d[2] = ref_d[1];
         ref_d[1] = ref_d[0];
         ref_d[0] = longint'(xa % 256) * longint'(xb % 256) + longint'(xc % 256);
      end
      compare(tag);
   endtask

   task automatic do_reset(input string tag);
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0; stall = 1'b0; flush = 1'b0;
      @(posedge clk);
      #1;
      for (int i = 0; i < 3; i++) ref_v[i] = 1'b0;
      compare(tag);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 3; i++) begin ref_v[i] = 1'b0; ref_d[i] = 0; end
      // reset state
      do_reset("R9 reset");
      // fill: a single op, out_valid must stay low for two cycles then rise
      step(1, 0, 0, 3, 5, 7, "R3 fill");
      step(0, 0, 0, 0, 0, 0, "R3 fill");
      step(0, 0, 0, 0, 0, 0, "R3 result 22");
      // back-to-back stream with varying c
      step(1, 0, 0, 2, 4, 1, "R2 stream");
      step(1, 0, 0, 3, 6, 10, "R4 varying c");
      step(1, 0, 0, 5, 7, 100, "R4 varying c");
      step(1, 0, 0, 9, 2, 3, "R1 stream");
      step(1, 0, 0, 1, 1, 200, "R4 varying c");
      // carry out of the low half
      step(1, 0, 0, 255, 1, 1, "R5 carry 256");
      step(1, 0, 0, 255, 255, 255, "R5 max 65280");
      step(1, 0, 0, 16, 16, 255, "R5 no carry 511");
      step(1, 0, 0, 254, 255, 200, "R5 near max");
      // bubbles
      step(0, 0, 0, 99, 99, 99, "R10 bubble");
      step(1, 0, 0, 7, 7, 7, "R10 after bubble");
      step(0, 0, 0, 0, 0, 0, "R10 bubble");
      step(1, 0, 0, 200, 3, 250, "R1 stream");
      // stall for two cycles with work in flight
      step(1, 1, 0, 11, 12, 13, "R6 stall hold");
      step(1, 1, 0, 11, 12, 13, "R6 stall hold");
      step(1, 0, 0, 11, 12, 13, "R6 resume");
      step(0, 0, 0, 0, 0, 0, "R6 resume");
      step(0, 0, 0, 0, 0, 0, "R6 resume");
      step(0, 0, 0, 0, 0, 0, "R6 resume");
      // flush with three in flight plus one offered on the flush cycle
      step(1, 0, 0, 20, 20, 20, "R7 pre");
      step(1, 0, 0, 21, 21, 21, "R7 pre");
      step(1, 0, 0, 22, 22, 22, "R7 pre");
      step(1, 0, 1, 23, 23, 23, "R7 flush");
      step(0, 0, 0, 0, 0, 0, "R7 drained");
      step(0, 0, 0, 0, 0, 0, "R7 drained");
      step(0, 0, 0, 0, 0, 0, "R7 drained");
      // stall and flush together: flush ignored
      step(1, 0, 0, 30, 31, 32, "R8 pre");
      step(1, 0, 0, 40, 41, 42, "R8 pre");
      step(1, 1, 1, 50, 51, 52, "R8 stall wins");
      step(0, 0, 0, 0, 0, 0, "R8 survives");
      step(0, 0, 0, 0, 0, 0, "R8 survives");
      step(0, 0, 0, 0, 0, 0, "R8 survives");
      // reset in mid stream
      step(1, 0, 0, 60, 61, 62, "R9 pre");
      step(1, 0, 0, 63, 64, 65, "R9 pre");
      do_reset("R9 mid reset");
      step(0, 0, 0, 0, 0, 0, "R9 empty");
      step(0, 0, 0, 0, 0, 0, "R9 empty");
      step(0, 0, 0, 0, 0, 0, "R9 empty");
      // random mix
      for (int n = 0; n < 400; n++) begin
         int r;
         r = int'($urandom_range(0, 99));
         step(r < 80, r >= 88, (r >= 85 && r < 87) || r == 99,
              int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
              int'($urandom_range(0, 255)), "R1 random");
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule